// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block turns the module clock into CAN time quanta and assembles them into nominal bits: a one-quantum synchronisation segment, then a programmable propagation segment, then phase segment 1, then phase segment 2. It samples the synchronised receive line at the end of phase segment 1. It can take either one sample or a three-sample majority vote. It reports the result together with a one-cycle sample strobe, and it marks the first cycle of every bit with a bit-start strobe.

The receive line uses recessive = 1 and dominant = 0. A recessive-to-dominant transition realigns the bit in one of two ways, chosen by `resync_en`. When it is low (bus idle), the transition restarts the bit outright. When it is high (inside a frame), the transition moves the sample point later or ends the bit earlier, by at most the jump width.

The configuration is captured only while reset is asserted. A zero code in either phase-segment field is illegal: it raises `cfg_err` and keeps the timing logic parked. The outputs are plain strobes with no back-pressure. A consumer must take `rx_bit` in the cycle `sample_stb` is high, because the block never waits.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `cfg_presc + 1` module clock cycles, giving 1 to 16 cycles.
- R2: With no realignment, the bit lasts `(1 + P + T1 + T2)` quanta, where P = `cfg_prop + 1`, T1 = `cfg_ph1 + 1` and T2 = `cfg_ph2 + 1`. `sample_stb` is high `(1 + P + T1)` quanta after the `bit_start` cycle, which is the first cycle after the sample point.
- R3: `sample_stb` and `bit_start` are single-cycle pulses and are never high together.
- R4: `rx_bit` changes only in a cycle where `sample_stb` is high. With `cfg_triple` = 0 it takes the line value seen in the sample-point quantum.
- R5: With `cfg_triple` = 1, `rx_bit` is the majority of the line values seen in the last three quanta up to and including the sample-point quantum.
- R6: With `resync_en` = 0, a falling edge on the line restarts the bit: `bit_start` fires at the start of the quantum that follows the one in which the edge is seen.
- R7: With `resync_en` = 1, a falling edge seen in quantum q, where 1 <= q <= sample-point index, moves the sample point and the bit end later by min(q, J) quanta. J = `cfg_sjw + 1`, giving 1 to 4.
- R8: With `resync_en` = 1, let a falling edge be seen in quantum q after the sample point, and let e be the number of quanta left in the bit after quantum q. If e <= J the bit ends after quantum q. Otherwise phase segment 2 is shortened by J.
- R9: Only the first falling edge in a bit realigns it. Later falling edges in the same bit are ignored.
- R10: If `cfg_ph1` or `cfg_ph2` is 000, `cfg_err` is high and neither strobe fires.
- R11: Configuration inputs are captured only while `rst_n` is low. Changing them afterwards has no effect until the next reset.
- R12: During reset, `sample_stb` and `bit_start` are low and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset; also the configuration capture window |
| cfg_presc | input | 4 | Quantum prescaler code (ratio = code + 1) |
| cfg_prop | input | 3 | Propagation segment code (length = code + 1 Tq) |
| cfg_ph1 | input | 3 | Phase segment 1 code (length = code + 1 Tq, 000 illegal) |
| cfg_ph2 | input | 3 | Phase segment 2 code (length = code + 1 Tq, 000 illegal) |
| cfg_sjw | input | 2 | Jump width code (width = code + 1 Tq) |
| cfg_triple | input | 1 | 1 = three-sample majority, 0 = single sample |
| resync_en | input | 1 | 1 = soft realignment inside a frame, 0 = hard restart (idle bus) |
| rx_in | input | 1 | Asynchronous receive line |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | One-cycle pulse when rx_bit is updated |
| bit_start | output | 1 | One-cycle pulse in the first cycle of each bit |
| cfg_err | output | 1 | Illegal phase-segment configuration |

## Verification
The assertions assume that the configuration is captured under reset and then held. They also assume that every legal bit lasts at least six quanta, so neither strobe can come back on the next cycle. No timing is assumed for `rx_in`, because it passes through the synchroniser. The stimulus changes `rx_in` and the configuration only on falling clock edges and always reaches a new configuration through a reset pulse, except in the one test that deliberately changes the configuration while the block is running. Timed line patterns use a prescaler ratio of 4, so each change lands in a known quantum despite the two-stage synchroniser.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int PRESC_W = 4;
  localparam int SEG_W   = 3;
  localparam int SJW_W   = 2;
  // Longest bit index: sync + three full segments + maximum extension.
  localparam int MAX_IDX = 3 * (2 ** SEG_W) + (2 ** SJW_W);
  localparam int Q_W     = $clog2(MAX_IDX + 1);

  typedef logic [Q_W-1:0] q_t;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [SEG_W-1:0]   prop;
    logic [SEG_W-1:0]   ph1;
    logic [SEG_W-1:0]   ph2;
    logic [SJW_W-1:0]   sjw;
    logic               triple;
  } bt_cfg_t;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_RESTART,
    ACT_EXTEND,
    ACT_SHORTEN
  } bt_act_e;

  function automatic q_t seg_len(input logic [SEG_W-1:0] code);
    return q_t'(code) + q_t'(1);
  endfunction

  function automatic q_t jump_len(input logic [SJW_W-1:0] code);
    return q_t'(code) + q_t'(1);
  endfunction

  function automatic q_t lesser(input q_t a, input q_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bt_cfg_t cfg_in,
  output bt_cfg_t cfg_q,
  output logic    cfg_err
);
  // Capture window is the reset period only; afterwards the word is frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cfg_in;
  end

  assign cfg_err = (cfg_q.ph1 == '0) || (cfg_q.ph2 == '0);
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
  import can_bt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;

  assign tick = run && (cnt == presc);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  cnt <= '0;
    else if (cnt == presc) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic tick,
  input  logic triple,
  output logic edge_det,
  output logic vote
);
  logic       rx_s;
  logic [1:0] hist;  // [0] = previous quantum, [1] = the one before

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_in;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= SYNC_STAGES'({chain, rx_in});
      end
      assign rx_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    hist <= 2'b11;
    else if (tick) hist <= {hist[0], rx_s};
  end

  // Falling edge between the previous quantum value and the current one.
  assign edge_det = tick && hist[0] && !rx_s;

  always_comb begin
    if (triple) vote = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
    else        vote = rx_s;
  end
endmodule

// File: rtl/can_bt_fsm.sv
module can_bt_fsm
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             edge_det,
  input  logic             vote,
  input  logic             resync_en,
  input  logic [SEG_W-1:0] prop,
  input  logic [SEG_W-1:0] ph1,
  input  logic [SEG_W-1:0] ph2,
  input  logic [SJW_W-1:0] sjw,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             bit_start
);
  q_t      q, ext, shr;
  logic    synced;
  q_t      sp, end_q, jw;
  bt_act_e act;
  logic    do_sample;

  assign jw    = jump_len(sjw);
  assign sp    = seg_len(prop) + seg_len(ph1) + ext;
  assign end_q = sp + seg_len(ph2) - shr;

  always_comb begin
    act       = ACT_HOLD;
    do_sample = 1'b0;
    if (tick) begin
      if (edge_det && !resync_en) begin
        act = ACT_RESTART;
      end else if (edge_det && !synced && (q != '0)) begin
        if (q <= sp)                  act = ACT_EXTEND;
        else if ((end_q - q) <= jw)   act = ACT_RESTART;
        else                          act = ACT_SHORTEN;
      end else begin
        do_sample = (q == sp);
        act       = (q == end_q) ? ACT_RESTART : ACT_STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    sample_stb <= 1'b0;
    bit_start  <= 1'b0;
    if (!rst_n || !run) begin
      q      <= '0;
      ext    <= '0;
      shr    <= '0;
      synced <= 1'b0;
      rx_bit <= 1'b1;
    end else begin
      if (do_sample) begin
        rx_bit     <= vote;
        sample_stb <= 1'b1;
      end
      case (act)
        ACT_STEP: q <= q + 1'b1;
        ACT_RESTART: begin
          q         <= '0;
          ext       <= '0;
          shr       <= '0;
          synced    <= 1'b0;
          bit_start <= 1'b1;
        end
        ACT_EXTEND: begin
          ext    <= lesser(q, jw);
          synced <= 1'b1;
          q      <= q + 1'b1;
        end
        ACT_SHORTEN: begin
          shr    <= jw;
          synced <= 1'b1;
          q      <= q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic [SEG_W-1:0]   cfg_prop,
  input  logic [SEG_W-1:0]   cfg_ph1,
  input  logic [SEG_W-1:0]   cfg_ph2,
  input  logic [SJW_W-1:0]   cfg_sjw,
  input  logic               cfg_triple,
  input  logic               resync_en,
  input  logic               rx_in,
  output logic               rx_bit,
  output logic               sample_stb,
  output logic               bit_start,
  output logic               cfg_err
);
  bt_cfg_t cfg_in, cfg_q;
  logic    run, tick, edge_det, vote;

  assign cfg_in = '{presc: cfg_presc, prop: cfg_prop, ph1: cfg_ph1,
                    ph2: cfg_ph2, sjw: cfg_sjw, triple: cfg_triple};
  assign run    = !cfg_err;

  can_bt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .cfg_q(cfg_q), .cfg_err(cfg_err)
  );

  can_bt_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(cfg_q.presc), .tick(tick)
  );

  can_bt_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(tick),
    .triple(cfg_q.triple), .edge_det(edge_det), .vote(vote)
  );

  can_bt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .edge_det(edge_det),
    .vote(vote), .resync_en(resync_en), .prop(cfg_q.prop), .ph1(cfg_q.ph1),
    .ph2(cfg_q.ph2), .sjw(cfg_q.sjw), .rx_bit(rx_bit),
    .sample_stb(sample_stb), .bit_start(bit_start)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_bit,
  input logic sample_stb,
  input logic bit_start,
  input logic cfg_err
);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start));

  a_r3_sample_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> !bit_start);

  a_r4_bit_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> sample_stb);

  a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!sample_stb && !bit_start));

  a_r11_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_err));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sample_stb(sample_stb),
  .bit_start(bit_start), .cfg_err(cfg_err)
);

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_presc = 4'd0;
  logic [2:0] cfg_prop = 3'd0, cfg_ph1 = 3'd1, cfg_ph2 = 3'd1;
  logic [1:0] cfg_sjw = 2'd0;
  logic       cfg_triple = 1'b0, resync_en = 1'b1, rx_in = 1'b1;
  logic       rx_bit, sample_stb, bit_start, cfg_err;

  int nchk = 0, nfail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_prop(cfg_prop),
    .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .cfg_triple(cfg_triple), .resync_en(resync_en), .rx_in(rx_in),
    .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_start(bit_start),
    .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [3:0] brp;
    logic [2:0] prop;
    logic [2:0] ph1;
    logic [2:0] ph2;
    int         bitc;
    int         sampc;
  } vec_t;

  // Expected: bit = (brp+1)*(1+P+T1+T2), sample = (brp+1)*(1+P+T1)
  localparam vec_t VECS [4] = '{
    '{4'd0,  3'd0, 3'd1, 3'd1, 6,   4},
    '{4'd3,  3'd2, 3'd3, 3'd2, 44,  32},
    '{4'd15, 3'd7, 3'd7, 3'd7, 400, 272},
    '{4'd1,  3'd4, 3'd2, 3'd5, 30,  18}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [3:0] p, input logic [2:0] pr,
                           input logic [2:0] a, input logic [2:0] b,
                           input logic [1:0] j, input logic t, input logic rs);
    @(negedge clk);
    cfg_presc = p; cfg_prop = pr; cfg_ph1 = a; cfg_ph2 = b;
    cfg_sjw = j; cfg_triple = t; resync_en = rs; rx_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_start(output int c);
    do @(negedge clk); while (!bit_start);
    c = cyc;
  endtask

  task automatic wait_sample(output int c);
    do @(negedge clk); while (!sample_stb);
    c = cyc;
  endtask

  // Timed pattern config: N=4, P=3, T1=4, T2=3, sample index 7, end index 10.
  task automatic vote_bit(input logic t, input logic a, input logic b,
                          input logic c, input logic exp_bit, input string tag);
    int c0, c1, c2;
    apply_cfg(4'd3, 3'd2, 3'd3, 3'd2, 2'd0, t, 1'b1);
    wait_start(c0);
    repeat (4)  @(negedge clk); rx_in = 1'b0;  // quantum 1: realign
    repeat (20) @(negedge clk); rx_in = a;     // quantum 6
    repeat (4)  @(negedge clk); rx_in = b;     // quantum 7
    repeat (4)  @(negedge clk); rx_in = c;     // quantum 8
    wait_sample(c1);
    chk({tag, " R7 R9 sample offset after extension"}, c1 - c0, 36);
    chk({tag, " sampled value"}, int'(rx_bit), int'(exp_bit));
    wait_start(c2);
    chk({tag, " R7 extended bit length"}, c2 - c0, 48);
    rx_in = 1'b1;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    int c0, c1, c2, cnt;

    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 sample_stb in reset", int'(sample_stb), 0);
    chk("R12 bit_start in reset", int'(bit_start), 0);
    chk("R12 rx_bit in reset", int'(rx_bit), 1);

    // R1 R2 nominal timing table
    for (int i = 0; i < 4; i++) begin
      apply_cfg(VECS[i].brp, VECS[i].prop, VECS[i].ph1, VECS[i].ph2, 2'd0, 1'b0, 1'b1);
      wait_start(c0);
      wait_sample(c1);
      wait_start(c2);
      chk($sformatf("R2 sample offset vec%0d", i), c1 - c0, VECS[i].sampc);
      chk($sformatf("R1 R2 bit period vec%0d", i), c2 - c0, VECS[i].bitc);
      chk($sformatf("R4 idle line bit vec%0d", i), int'(rx_bit), 1);
    end

    // R11 config change after reset is ignored
    apply_cfg(4'd3, 3'd2, 3'd3, 3'd2, 2'd0, 1'b0, 1'b1);
    cfg_presc = 4'd0; cfg_prop = 3'd0; cfg_ph1 = 3'd1; cfg_ph2 = 3'd1;
    wait_start(c0);
    wait_start(c2);
    chk("R11 period unchanged by live config edit", c2 - c0, 44);
    chk("R11 no error from live config edit", int'(cfg_err), 0);

    // R4 R5 voting with R7 R9 realignment
    vote_bit(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 single A");
    vote_bit(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 triple A");
    vote_bit(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5 triple B");
    vote_bit(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 single B");

    // R8 shortening: edge in quantum 8, 2 quanta left
    apply_cfg(4'd3, 3'd2, 3'd3, 3'd2, 2'd1, 1'b0, 1'b1);
    wait_start(c0);
    repeat (32) @(negedge clk); rx_in = 1'b0;
    wait_start(c2);
    chk("R8 bit ends at edge (J=2)", c2 - c0, 36);
    rx_in = 1'b1;

    apply_cfg(4'd3, 3'd2, 3'd3, 3'd2, 2'd0, 1'b0, 1'b1);
    wait_start(c0);
    repeat (32) @(negedge clk); rx_in = 1'b0;
    wait_start(c2);
    chk("R8 phase 2 cut by J=1", c2 - c0, 40);
    rx_in = 1'b1;

    // R6 hard restart on idle bus
    apply_cfg(4'd3, 3'd2, 3'd3, 3'd2, 2'd0, 1'b0, 1'b0);
    wait_start(c0);
    repeat (20) @(negedge clk); rx_in = 1'b0;
    wait_start(c2);
    chk("R6 hard restart after quantum 5", c2 - c0, 24);
    rx_in = 1'b1;
    wait_start(c0);
    wait_start(c2);
    chk("R6 nominal bit after restart", c2 - c0, 44);

    // R10 illegal phase codes
    apply_cfg(4'd0, 3'd0, 3'd0, 3'd2, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R10 error for phase1 code 000", int'(cfg_err), 1);
    cnt = 0;
    repeat (300) begin
      @(negedge clk);
      if (sample_stb || bit_start) cnt++;
    end
    chk("R10 no strobes with phase1 000", cnt, 0);

    apply_cfg(4'd0, 3'd0, 3'd2, 3'd0, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R10 error for phase2 code 000", int'(cfg_err), 1);
    cnt = 0;
    repeat (300) begin
      @(negedge clk);
      if (sample_stb || bit_start) cnt++;
    end
    chk("R10 no strobes with phase2 000", cnt, 0);

    apply_cfg(4'd0, 3'd0, 3'd1, 3'd1, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R10 error clears with legal codes", int'(cfg_err), 0);
    wait_start(c0);
    wait_start(c2);
    chk("R10 timing resumes after legal reset", c2 - c0, 6);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule